// File: doc/BRIEF.md
# Clock Interrupt Flag Controller

This block sits beside a real-time clock's timekeeping logic and turns three event pulses into one interrupt line. The events are a periodic divider tap, an alarm match and the end of a per-second update. Each event latches a sticky flag in a status register. The flag latches whether or not its source is enabled. A control register holds one enable per source. The interrupt goes high when at least one latched flag has its enable set.

Software reaches both registers through a small indexed port: an address, a write strobe, a read strobe and a byte of write data. Read data is combinational. A status read returns the current flags and the summary request bit in the same cycle. At the following clock edge the read clears every bit of the status register, unless an event arrives in that same cycle.

The interrupt level comes from a two-state request machine. `REQ_IDLE` moves to `REQ_ACTIVE` by the transition RAISE when the next-cycle flags and enables hold a pending enabled source. `REQ_ACTIVE` returns to `REQ_IDLE` by the transition DROP when no pending enabled source remains, either after a status read or after a control write that removes the enables. Each state otherwise holds.

Top module: `rtcirq_flag_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00 and `irq` is low.
- R2: A write at index 0xB stores all eight bits of the control register, and a read at 0xB returns them. Bits 3..0 are storage only and never affect `irq`.
- R3: A pulse on `ev_periodic`, `ev_alarm` or `ev_update` sets status bit 6, 5 or 4 respectively at the next clock edge, whatever the enables hold. The flag then stays set until a status read.
- R4: Status bit 7, the request flag, is 1 exactly when some status bit 6/5/4 is set together with control bit 6/5/4 of the same position.
- R5: `irq` is a level equal to status bit 7. Once high it stays high until a status read or a control write removes every enabled pending source.
- R6: A read at index 0xC returns the current status byte in the same cycle and clears bits 7..4 at the next clock edge.
- R7: An event in the same cycle as a status read wins. Its flag is set after that edge, and the request flag and `irq` follow its enable.
- R8: Writes to index 0xC are ignored, and the status contents stay unchanged.
- R9: Status bits 3..0 read as 0. Reads at any index other than 0xB and 0xC return 0x00 and clear nothing.
- R10: Setting an enable while its flag is latched raises `irq` one edge after the write. Clearing the enable lowers `irq` one edge after the write, and the flag stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_periodic | input | 1 | Periodic divider tap event pulse |
| ev_alarm | input | 1 | Alarm match event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| reg_addr | input | ADDR_W (4) | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (status read clears) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
Read data is due in the same cycle as the read strobe. The bench drives each strobe just after a falling edge and samples `reg_rdata` one time unit later, before the rising edge. Flags, the request bit and `irq` change at the rising edge that samples an event or a write, and a status read clears them at that same edge. Every state check therefore runs at the next falling edge after the stimulus is removed. The bench sweeps all eight enable patterns against all eight event patterns and all 256 control values. Its expected bytes are built arithmetically as enables ANDed with events, shifted into bits 6..4, with bit 7 their reduction OR.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;
    localparam int DATA_W  = 8;
    localparam int NUM_SRC = 3;
    localparam int SRC_LSB = 4;
    localparam int REQ_BIT = 7;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_t;
endpackage

// File: rtl/rtcirq_ctrl_reg.sv
module rtcirq_ctrl_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_nxt
);
    always_comb q_nxt = we ? d : q;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));
endmodule

// File: rtl/rtcirq_flag.sv
module rtcirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q,
    output logic q_nxt
);
    always_comb q_nxt = set_i | (q & ~clr_i);

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_nxt;
    end

    // R3 R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);
    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_i) |=> q);
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q);
endmodule

// File: rtl/rtcirq_flag_ctrl.sv
module rtcirq_flag_ctrl
    import rtcirq_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTRL_IDX = 'hB,
    parameter logic [ADDR_W-1:0] STAT_IDX = 'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_periodic,
    input  logic              ev_alarm,
    input  logic              ev_update,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic               sel_ctrl, sel_stat, ctrl_we, stat_rd;
    logic [DATA_W-1:0]  ctrl_q, ctrl_nxt, stat_val;
    logic [NUM_SRC-1:0] ev_vec, flag_q, flag_nxt, en_q, en_nxt;
    logic               pend_nxt;
    req_state_t         state, state_nxt;

    always_comb begin
        sel_ctrl = (reg_addr == CTRL_IDX);
        sel_stat = (reg_addr == STAT_IDX);
        ctrl_we  = reg_wr & sel_ctrl;
        stat_rd  = reg_rd & sel_stat;
        ev_vec   = {ev_periodic, ev_alarm, ev_update};
    end

    rtcirq_ctrl_reg #(.W(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .d     (reg_wdata),
        .q     (ctrl_q),
        .q_nxt (ctrl_nxt)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        rtcirq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ev_vec[i]),
            .clr_i (stat_rd),
            .q     (flag_q[i]),
            .q_nxt (flag_nxt[i])
        );
    end

    always_comb begin
        en_q     = ctrl_q[SRC_LSB +: NUM_SRC];
        en_nxt   = ctrl_nxt[SRC_LSB +: NUM_SRC];
        pend_nxt = |(flag_nxt & en_nxt);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= REQ_IDLE;
        else        state <= state_nxt;
    end

    // transitions: RAISE (idle->active), DROP (active->idle)
    always_comb begin
        state_nxt = state;
        unique case (state)
            REQ_IDLE:   if (pend_nxt)  state_nxt = REQ_ACTIVE;
            REQ_ACTIVE: if (!pend_nxt) state_nxt = REQ_IDLE;
            default:    state_nxt = REQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq                          = (state == REQ_ACTIVE);
        stat_val                     = '0;
        stat_val[REQ_BIT]            = irq;
        stat_val[SRC_LSB +: NUM_SRC] = flag_q;
        if (sel_ctrl)      reg_rdata = ctrl_q;
        else if (sel_stat) reg_rdata = stat_val;
        else               reg_rdata = '0;
    end

    // R4
    req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(flag_q & en_q));
    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_rd && !ctrl_we) |=> irq);
    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ev_vec == '0) |=> (flag_q == '0 && !irq));
    // R8
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_stat && !reg_rd && ev_vec == '0) |=> $stable(flag_q));
endmodule

// File: tb/rtcirq_flag_ctrl_bench.sv
module rtcirq_flag_ctrl_bench;
    localparam logic [3:0] CTRL = 4'hB;
    localparam logic [3:0] STAT = 4'hC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_periodic = 1'b0, ev_alarm = 1'b0, ev_update = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    rtcirq_flag_ctrl u_rtcirq_flag_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_ev(input logic [3:0] a, input logic [2:0] ev);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        {ev_periodic, ev_alarm, ev_update} = ev;
        #1 rv = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        {ev_periodic, ev_alarm, ev_update} = 3'b000;
    endtask

    task automatic rd(input logic [3:0] a);
        rd_ev(a, 3'b000);
    endtask

    task automatic pulse(input logic [2:0] ev);
        @(negedge clk);
        {ev_periodic, ev_alarm, ev_update} = ev;
        @(negedge clk);
        {ev_periodic, ev_alarm, ev_update} = 3'b000;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual 00 expected 01");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd(CTRL); chk("R1 ctrl", rv, 8'h00);
        rd(STAT); chk("R1 status", rv, 8'h00);

        // R2 control storage, storage-only bits have no effect
        for (int v = 0; v < 256; v++) begin
            wr(CTRL, 8'(v));
            rd(CTRL);
            chk("R2 readback", rv, 8'(v));
            chk("R2 no irq", {7'd0, irq}, 8'h00);
        end

        // R3 R4 R6 sweep of enables x events
        for (int en = 0; en < 8; en++) begin
            for (int ev = 0; ev < 8; ev++) begin
                logic [7:0] exp;
                rd(STAT);
                wr(CTRL, 8'(en << 4));
                pulse(3'(ev));
                exp = 8'(ev << 4) | (((en & ev) != 0) ? 8'h80 : 8'h00);
                chk("R4 irq level", {7'd0, irq}, {7'd0, exp[7]});
                rd(STAT);
                chk("R3 status", rv, exp);
                chk("R6 cleared irq", {7'd0, irq}, 8'h00);
                rd(STAT);
                chk("R6 cleared status", rv, 8'h00);
            end
        end

        // R5 level hold
        wr(CTRL, 8'h20);
        pulse(3'b010);
        repeat (5) @(negedge clk);
        chk("R5 hold", {7'd0, irq}, 8'h01);
        rd(STAT);
        chk("R5 read", rv, 8'hA0);
        chk("R5 released", {7'd0, irq}, 8'h00);

        // R7 event wins over clearing read
        wr(CTRL, 8'h70);
        rd_ev(STAT, 3'b111);
        chk("R7 rdata", rv, 8'h00);
        chk("R7 irq", {7'd0, irq}, 8'h01);
        rd(STAT);
        chk("R7 status", rv, 8'hF0);
        pulse(3'b100);
        rd_ev(STAT, 3'b010);
        chk("R7 pre", rv, 8'hC0);
        rd(STAT);
        chk("R7 post", rv, 8'hA0);
        wr(CTRL, 8'h00);
        rd_ev(STAT, 3'b001);
        chk("R7 disabled irq", {7'd0, irq}, 8'h00);
        rd(STAT);
        chk("R7 disabled status", rv, 8'h10);

        // R8 writes to status ignored
        wr(STAT, 8'hFF);
        rd(STAT);
        chk("R8 empty", rv, 8'h00);
        wr(CTRL, 8'h40);
        pulse(3'b100);
        wr(STAT, 8'h00);
        chk("R8 irq", {7'd0, irq}, 8'h01);
        rd(STAT);
        chk("R8 kept", rv, 8'hC0);

        // R9 other indices read 0 and do not clear
        pulse(3'b111);
        for (int a = 0; a < 16; a++) begin
            if (a != 11 && a != 12) begin
                rd(4'(a));
                chk("R9 other index", rv, 8'h00);
            end
        end
        rd(STAT);
        chk("R9 not cleared", rv, 8'hF0);

        // R10 enable after latch
        wr(CTRL, 8'h00);
        pulse(3'b001);
        chk("R10 no irq", {7'd0, irq}, 8'h00);
        wr(CTRL, 8'h10);
        chk("R10 raise", {7'd0, irq}, 8'h01);
        wr(CTRL, 8'h0F);
        chk("R10 drop", {7'd0, irq}, 8'h00);
        rd(STAT);
        chk("R10 latched", rv, 8'h10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule